// File: doc/BRIEF.md
# CompactFlash True-IDE Bus Cycle Engine

This block turns single host requests into timed static-memory bus cycles for a CompactFlash card in True IDE mode. The host gives a register address, write data, a direction flag, a width flag and a one-cycle start strobe. The engine drives the card's chip select, read and write strobes, register address lines, window select, byte-lane width and data direction. It returns read data with a one-cycle completion pulse. The data register and the task-file registers share one address and differ only by access width. A 16-bit request uses the full bus. An 8-bit request uses only the low byte lane.

Four timing counts, all in clock cycles, shape each access: strobe setup, strobe pulse, total cycle length and post-read data float. They sit in a small register bank that is loaded in one cycle and reset to slow-mode values. An optional wait on the card's ready line stretches the strobe for as long as the card holds ready low. After a read, a float interval keeps the bus quiet so the card can release the data lines. A start that arrives during an access or a float interval is held in a one-entry slot and issued as soon as the engine becomes idle.

Top module: `cfide_bus_engine`

## Requirements
- R1: Bit 3 of `req_addr` selects the window on `bus_alt`: 1 is the alternate status/control window and 0 is the task-file window. Bits 2:0 appear on `bus_reg`. Both hold for every cycle in which `bus_cs_n` is low.
- R2: A request with `req_wide`=1 sets `bus_wide`=1, drives all 16 bits of `req_wdata` and returns all 16 bits of `bus_din`. With `req_wide`=0, `bus_wide` is 0, the upper byte of `bus_dout` is 0, and the upper byte of `rsp_rdata` is 0.
- R3: Chip select has zero setup. `bus_cs_n` goes low in the cycle after a request is accepted. It stays low for the programmed cycle count plus any ready-wait cycles.
- R4: For a read, `bus_rd_n` goes low after `setup` cycles of chip select and stays low for `pulse` cycles. A write does the same on `bus_wr_n`. The other strobe stays high throughout. A programmed pulse of 0 is taken as 1.
- R5: If the cycle count is less than setup plus pulse, the access lasts setup plus pulse cycles.
- R6: With ready waiting enabled, each cycle in which `io_rdy` is low during the last strobe cycle adds one cycle to the strobe and to the access. With waiting disabled, `io_rdy` has no effect.
- R7: Read data is taken from `bus_din` on the clock edge that raises `bus_rd_n`. `rsp_rdata` holds that value until the next read ends. Writes leave it unchanged.
- R8: `rsp_done` is high for exactly one cycle per access: the first cycle in which `bus_cs_n` is high again.
- R9: After a read with float count F, at least F+1 cycles with `bus_cs_n` high pass before the next access. After a write, a waiting request starts after exactly one such cycle.
- R10: A start that arrives while an access or float interval is running is held in one slot and issued when the engine goes idle. A further start while the slot is full is dropped.
- R11: After reset the timing counts are setup 7, pulse 17, cycle 60 and float 3, and ready waiting is off. The outputs are idle: `bus_cs_n`, `bus_rd_n` and `bus_wr_n` high, `rsp_done` and `bus_doe` low, `rsp_rdata` 0. A `cfg_wr` pulse loads all five timing fields for later accesses.
- R12: `bus_doe` is high for every chip-select-low cycle of a write and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load all timing fields |
| cfg_setup | input | 8 | Strobe setup count |
| cfg_pulse | input | 8 | Strobe pulse count |
| cfg_cycle | input | 8 | Total cycle count |
| cfg_float | input | 8 | Post-read float count |
| cfg_iordy_en | input | 1 | Enable ready waiting |
| req_start | input | 1 | Request strobe |
| req_addr | input | 4 | Bit 3 window, bits 2:0 register |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 16-bit data register access |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Last read data |
| bus_cs_n | output | 1 | Card chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_alt | output | 1 | Alternate window select |
| bus_reg | output | 3 | Register address lines |
| bus_wide | output | 1 | 16-bit lane width |
| bus_doe | output | 1 | Data bus drive enable |
| bus_dout | output | 16 | Data driven to card |
| bus_din | input | 16 | Data from card |
| io_rdy | input | 1 | Card ready line |

## Verification
The hardest case to reach is a request waiting in the holding slot while the float interval of an earlier read is still running. The bench reaches it by issuing a second start shortly after the first read begins, with short timing counts loaded. The second hardest case is a strobe stretched by the ready line at exactly its last cycle. The bench holds `io_rdy` low before the access starts and releases it a fixed number of cycles later. In both cases a bench-side model tracks cycle positions as integers and sets the expected chip-select gap and access length.

// File: rtl/cfide_pkg.sv
package cfide_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD, PH_FLT
  } phase_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              write;
    logic              wide;
  } req_t;
endpackage

// File: rtl/cfide_timing_regs.sv
module cfide_timing_regs #(
  parameter int CNT_W     = 8,
  parameter int RST_SETUP = 7,
  parameter int RST_PULSE = 17,
  parameter int RST_CYCLE = 60,
  parameter int RST_FLOAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic [CNT_W-1:0] cfg_cycle,
  input  logic [CNT_W-1:0] cfg_float,
  input  logic             cfg_iordy_en,
  output logic [CNT_W-1:0] t_setup,
  output logic [CNT_W-1:0] t_pulse,
  output logic [CNT_W-1:0] t_hold,
  output logic [CNT_W-1:0] t_float,
  output logic             t_iordy
);
  localparam int RST_PULSE_C = (RST_PULSE == 0) ? 1 : RST_PULSE;
  localparam int RST_HOLD    = (RST_CYCLE > RST_SETUP + RST_PULSE_C) ?
                               (RST_CYCLE - RST_SETUP - RST_PULSE_C) : 0;

  logic [CNT_W-1:0] pulse_c;
  logic [CNT_W:0]   strobe_end;
  logic [CNT_W:0]   hold_w;

  always_comb begin
    pulse_c    = (cfg_pulse == '0) ? CNT_W'(1) : cfg_pulse;
    strobe_end = {1'b0, cfg_setup} + {1'b0, pulse_c};
    hold_w     = ({1'b0, cfg_cycle} > strobe_end) ? ({1'b0, cfg_cycle} - strobe_end) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_setup <= CNT_W'(RST_SETUP);
      t_pulse <= CNT_W'(RST_PULSE_C);
      t_hold  <= CNT_W'(RST_HOLD);
      t_float <= CNT_W'(RST_FLOAT);
      t_iordy <= 1'b0;
    end else if (cfg_wr) begin
      t_setup <= cfg_setup;
      t_pulse <= pulse_c;
      t_hold  <= hold_w[CNT_W-1:0];
      t_float <= cfg_float;
      t_iordy <= cfg_iordy_en;
    end
  end

  // R4: the strobe count can never be zero
  a_r4_pulse_nonzero: assert property (@(posedge clk) disable iff (rst) t_pulse != '0);
endmodule

// File: rtl/cfide_req_slot.sv
module cfide_req_slot
  import cfide_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_start,
  input  req_t req_in,
  input  logic idle,
  output logic go,
  output req_t go_req
);
  logic pend_v;
  req_t pend;
  logic take_pend, take_new, store;

  always_comb begin
    take_pend = idle && pend_v;
    take_new  = idle && !pend_v && req_start;
    store     = req_start && !take_new && (!pend_v || take_pend);
    go        = take_pend || take_new;
    go_req    = pend_v ? pend : req_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend   <= '0;
    end else begin
      if (store) begin
        pend_v <= 1'b1;
        pend   <= req_in;
      end else if (take_pend) begin
        pend_v <= 1'b0;
      end
    end
  end

  // R10: a held request survives until the engine is idle
  a_r10_hold_until_idle: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !idle) |=> pend_v);
  // R10: an idle engine never leaves a request waiting
  a_r10_idle_drains: assert property (@(posedge clk) disable iff (rst)
    (pend_v && idle) |-> go);
endmodule

// File: rtl/cfide_seq.sv
module cfide_seq
  import cfide_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  req_t              go_req,
  input  logic [CNT_W-1:0]  t_setup,
  input  logic [CNT_W-1:0]  t_pulse,
  input  logic [CNT_W-1:0]  t_hold,
  input  logic [CNT_W-1:0]  t_float,
  input  logic              t_iordy,
  input  logic              io_rdy,
  input  logic [DATA_W-1:0] bus_din,
  output logic              idle,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_alt,
  output logic [2:0]        bus_reg,
  output logic              bus_wide,
  output logic              bus_doe,
  output logic [DATA_W-1:0] bus_dout
);
  localparam int HALF = DATA_W / 2;

  phase_t           phase, n_phase;
  logic [CNT_W-1:0] cnt, n_cnt;
  req_t             cur;
  logic             n_cs, n_rd, n_wr, n_doe, n_done, n_cap, finish, waiting;

  assign idle = (phase == PH_IDLE);
  assign waiting = t_iordy && !io_rdy;

  always_comb begin
    n_phase = phase;
    n_cnt   = cnt;
    n_cs    = bus_cs_n;
    n_rd    = bus_rd_n;
    n_wr    = bus_wr_n;
    n_doe   = bus_doe;
    n_done  = 1'b0;
    n_cap   = 1'b0;
    finish  = 1'b0;
    case (phase)
      PH_IDLE: if (go) begin
        n_cs  = 1'b0;
        n_doe = go_req.write;
        n_cnt = '0;
        if (t_setup == '0) begin
          n_phase = PH_STRB;
          n_rd    = go_req.write;
          n_wr    = !go_req.write;
        end else begin
          n_phase = PH_SETUP;
        end
      end
      PH_SETUP: if (cnt == t_setup - 1'b1) begin
        n_phase = PH_STRB;
        n_cnt   = '0;
        n_rd    = cur.write;
        n_wr    = !cur.write;
      end else begin
        n_cnt = cnt + 1'b1;
      end
      PH_STRB: if (cnt == t_pulse - 1'b1) begin
        if (!waiting) begin
          n_rd  = 1'b1;
          n_wr  = 1'b1;
          n_cap = !cur.write;
          if (t_hold != '0) begin
            n_phase = PH_HOLD;
            n_cnt   = '0;
          end else begin
            finish = 1'b1;
          end
        end
      end else begin
        n_cnt = cnt + 1'b1;
      end
      PH_HOLD: if (cnt == t_hold - 1'b1) finish = 1'b1;
               else n_cnt = cnt + 1'b1;
      PH_FLT: if (cnt == t_float - 1'b1) n_phase = PH_IDLE;
              else n_cnt = cnt + 1'b1;
      default: n_phase = PH_IDLE;
    endcase
    if (finish) begin
      n_cs    = 1'b1;
      n_doe   = 1'b0;
      n_done  = 1'b1;
      n_cnt   = '0;
      n_phase = (!cur.write && t_float != '0) ? PH_FLT : PH_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur       <= '0;
      bus_cs_n  <= 1'b1;
      bus_rd_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_doe   <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      bus_alt   <= 1'b0;
      bus_reg   <= '0;
      bus_wide  <= 1'b0;
      bus_dout  <= '0;
    end else begin
      phase    <= n_phase;
      cnt      <= n_cnt;
      bus_cs_n <= n_cs;
      bus_rd_n <= n_rd;
      bus_wr_n <= n_wr;
      bus_doe  <= n_doe;
      rsp_done <= n_done;
      if (idle && go) begin
        cur      <= go_req;
        bus_alt  <= go_req.addr[3];
        bus_reg  <= go_req.addr[2:0];
        bus_wide <= go_req.wide;
        bus_dout <= go_req.wide ? go_req.wdata : {{HALF{1'b0}}, go_req.wdata[HALF-1:0]};
      end
      if (n_cap)
        rsp_rdata <= cur.wide ? bus_din : {{HALF{1'b0}}, bus_din[HALF-1:0]};
    end
  end

  // R4: never both strobes at once
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst) !(!bus_rd_n && !bus_wr_n));
  // R3: strobes only inside chip select
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);
  // R12: data drive only for a write under chip select
  a_r12_doe_write: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (!bus_cs_n && cur.write));
  // R8: completion is a single cycle with chip select released
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done);
  a_r8_done_cs_high: assert property (@(posedge clk) disable iff (rst) rsp_done |-> bus_cs_n);
  // R6: card not ready at the last strobe cycle keeps the strobe
  a_r6_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STRB && cnt == t_pulse - 1'b1 && waiting) |=> ($stable(bus_rd_n) && $stable(bus_wr_n)));
  // R9: the float interval keeps the bus released
  a_r9_float_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FLT) |-> (bus_cs_n && !bus_doe));
  // R7: read data only moves at the end of a read strobe
  a_r7_rdata_at_strobe_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> ($past(!bus_rd_n) && bus_rd_n));
endmodule

// File: rtl/cfide_bus_engine.sv
module cfide_bus_engine
  import cfide_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RST_SETUP = 7,
  parameter int RST_PULSE = 17,
  parameter int RST_CYCLE = 60,
  parameter int RST_FLOAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_pulse,
  input  logic [CNT_W-1:0]  cfg_cycle,
  input  logic [CNT_W-1:0]  cfg_float,
  input  logic              cfg_iordy_en,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_wide,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_alt,
  output logic [2:0]        bus_reg,
  output logic              bus_wide,
  output logic              bus_doe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              io_rdy
);
  logic [CNT_W-1:0] t_setup, t_pulse, t_hold, t_float;
  logic             t_iordy, idle, go;
  req_t             req_in, go_req;

  assign req_in = '{addr: req_addr, wdata: req_wdata, write: req_write, wide: req_wide};

  cfide_timing_regs #(
    .CNT_W(CNT_W), .RST_SETUP(RST_SETUP), .RST_PULSE(RST_PULSE),
    .RST_CYCLE(RST_CYCLE), .RST_FLOAT(RST_FLOAT)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_setup(cfg_setup),
    .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle), .cfg_float(cfg_float),
    .cfg_iordy_en(cfg_iordy_en), .t_setup(t_setup), .t_pulse(t_pulse),
    .t_hold(t_hold), .t_float(t_float), .t_iordy(t_iordy)
  );

  cfide_req_slot u_slot (
    .clk(clk), .rst(rst), .req_start(req_start), .req_in(req_in),
    .idle(idle), .go(go), .go_req(go_req)
  );

  cfide_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .go_req(go_req),
    .t_setup(t_setup), .t_pulse(t_pulse), .t_hold(t_hold),
    .t_float(t_float), .t_iordy(t_iordy), .io_rdy(io_rdy), .bus_din(bus_din),
    .idle(idle), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_alt(bus_alt), .bus_reg(bus_reg), .bus_wide(bus_wide),
    .bus_doe(bus_doe), .bus_dout(bus_dout)
  );
endmodule

// File: tb/tb_cfide_bus_engine.sv
`timescale 1ns/1ps
module tb_cfide_bus_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_iordy_en = 0;
  logic [7:0] cfg_setup = 0, cfg_pulse = 0, cfg_cycle = 0, cfg_float = 0;
  logic req_start = 0, req_write = 0, req_wide = 0;
  logic [3:0] req_addr = 0;
  logic [15:0] req_wdata = 0, bus_din = 0;
  logic io_rdy = 1'b1;
  logic rsp_done, bus_cs_n, bus_rd_n, bus_wr_n, bus_alt, bus_wide, bus_doe;
  logic [15:0] rsp_rdata, bus_dout;
  logic [2:0] bus_reg;

  always #5 clk = ~clk;

  cfide_bus_engine dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_setup(cfg_setup),
    .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle), .cfg_float(cfg_float),
    .cfg_iordy_en(cfg_iordy_en), .req_start(req_start), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_wide(req_wide),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_alt(bus_alt),
    .bus_reg(bus_reg), .bus_wide(bus_wide), .bus_doe(bus_doe),
    .bus_dout(bus_dout), .bus_din(bus_din), .io_rdy(io_rdy)
  );

  typedef struct { int addr; int wdata; bit rd; bit wide; } mreq_t;

  int total = 0, bad = 0, cyc = 0;
  // reference model state
  int m_state, m_pos, m_send, m_total, m_as, m_fcnt;
  int m_s, m_p, m_c, m_f;
  bit m_iordy;
  mreq_t m_cur;
  mreq_t pq[$];
  int m_rdata;
  bit e_cs, e_rd, e_wr, e_doe, e_done;
  // measurement
  int run = 0, gap = 0, last_len = 0, last_gap = 0, n_done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic begin_access(input mreq_t r);
    m_cur = r; m_state = 1; m_pos = 0; m_as = m_s;
    m_send = m_s + m_p;
    m_total = (m_c > m_s + m_p) ? m_c : m_s + m_p;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst) begin
      m_state = 0; m_s = 7; m_p = 17; m_c = 60; m_f = 3; m_iordy = 0;
      m_rdata = 0; pq.delete();
      e_cs = 1; e_rd = 1; e_wr = 1; e_doe = 0; e_done = 0;
    end else begin
      // measurement of chip-select runs and gaps
      if (!bus_cs_n) begin
        if (run == 0) last_gap = gap;
        run++; gap = 0;
      end else begin
        if (run != 0) last_len = run;
        run = 0; gap++;
      end
      if (rsp_done) n_done++;
      // compare against the model
      chk("R3 cs_n", bus_cs_n, e_cs);
      chk("R4 R6 rd_n", bus_rd_n, e_rd);
      chk("R4 R6 wr_n", bus_wr_n, e_wr);
      chk("R12 doe", bus_doe, e_doe);
      chk("R8 done", rsp_done, e_done);
      chk("R7 rdata", rsp_rdata, m_rdata);
      if (m_state == 1) begin
        chk("R1 alt", bus_alt, (m_cur.addr >> 3) & 1);
        chk("R1 reg", bus_reg, m_cur.addr & 7);
        chk("R2 wide", bus_wide, m_cur.wide);
        if (!m_cur.rd)
          chk("R2 dout", bus_dout, m_cur.wide ? m_cur.wdata : (m_cur.wdata & 'hff));
      end
      // advance the model by one clock
      e_done = 0;
      case (m_state)
        1: begin
          if (m_pos == m_send - 1 && m_iordy && !io_rdy) begin
            m_send++; m_total++;
          end else if (m_pos == m_send - 1 && m_cur.rd) begin
            m_rdata = m_cur.wide ? int'(bus_din) : int'(bus_din[7:0]);
          end
          m_pos++;
          if (m_pos == m_total) begin
            e_done = 1;
            if (m_cur.rd && m_f > 0) begin m_state = 2; m_fcnt = m_f; end
            else m_state = 0;
          end
          if (req_start && pq.size() == 0)
            pq.push_back('{int'(req_addr), int'(req_wdata), !req_write, req_wide});
        end
        2: begin
          m_fcnt--;
          if (m_fcnt == 0) m_state = 0;
          if (req_start && pq.size() == 0)
            pq.push_back('{int'(req_addr), int'(req_wdata), !req_write, req_wide});
        end
        default: begin
          if (pq.size() != 0) begin
            begin_access(pq.pop_front());
            if (req_start)
              pq.push_back('{int'(req_addr), int'(req_wdata), !req_write, req_wide});
          end else if (req_start) begin
            begin_access('{int'(req_addr), int'(req_wdata), !req_write, req_wide});
          end
        end
      endcase
      if (cfg_wr) begin
        m_s = cfg_setup; m_p = (cfg_pulse == 0) ? 1 : cfg_pulse;
        m_c = cfg_cycle; m_f = cfg_float; m_iordy = cfg_iordy_en;
      end
      e_cs  = (m_state != 1);
      e_rd  = !(m_state == 1 && m_cur.rd && m_pos >= m_as && m_pos < m_send);
      e_wr  = !(m_state == 1 && !m_cur.rd && m_pos >= m_as && m_pos < m_send);
      e_doe = (m_state == 1 && !m_cur.rd);
    end
  end

  task automatic start(input int addr, input int wd, input bit wr, input bit wide);
    @(posedge clk); #1;
    req_start = 1; req_addr = addr[3:0]; req_wdata = wd[15:0];
    req_write = wr; req_wide = wide;
    @(posedge clk); #1;
    req_start = 0;
  endtask

  task automatic wait_quiet();
    do @(negedge clk); while (!(m_state == 0 && pq.size() == 0));
    repeat (2) @(negedge clk);
  endtask

  task automatic access(input int addr, input int wd, input bit wr, input bit wide);
    start(addr, wd, wr, wide);
    wait_quiet();
  endtask

  task automatic config_t(input int s, input int p, input int c, input int f, input bit en);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_setup = s[7:0]; cfg_pulse = p[7:0]; cfg_cycle = c[7:0];
    cfg_float = f[7:0]; cfg_iordy_en = en;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  initial begin
    int d0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R11: idle outputs after reset
    chk("R11 reset cs_n", bus_cs_n, 1);
    chk("R11 reset rd_n", bus_rd_n, 1);
    chk("R11 reset wr_n", bus_wr_n, 1);
    chk("R11 reset done", rsp_done, 0);
    chk("R11 reset doe", bus_doe, 0);
    chk("R11 reset rdata", rsp_rdata, 0);

    // R11 default timing, R2 narrow read
    bus_din = 16'hA55A;
    access(4'h2, 0, 0, 0);
    chk("R11 default length", last_len, 60);
    chk("R2 narrow read", rsp_rdata, 16'h005A);

    // R2 wide read
    bus_din = 16'hBEEF;
    access(4'h0, 0, 0, 1);
    chk("R2 wide read", rsp_rdata, 16'hBEEF);

    // short timing; R1 alternate window write, R7 hold over writes
    config_t(2, 3, 8, 2, 0);
    access(4'hE, 16'h1234, 1, 0);
    chk("R3 programmed length", last_len, 8);
    chk("R7 rdata held over write", rsp_rdata, 16'hBEEF);
    access(4'h8, 16'hCAFE, 1, 1);

    // R5 cycle shorter than setup + pulse
    config_t(2, 3, 3, 0, 0);
    access(4'h1, 0, 0, 0);
    chk("R5 extended length", last_len, 5);

    // R4 zero setup, single pulse
    config_t(0, 1, 0, 0, 0);
    access(4'h7, 16'h00FF, 1, 0);
    chk("R4 minimal length", last_len, 1);
    // R4 pulse of zero taken as one
    config_t(1, 0, 0, 0, 0);
    access(4'h3, 16'h0011, 1, 0);
    chk("R4 zero pulse length", last_len, 2);

    // R6 waiting disabled: io_rdy low has no effect
    config_t(2, 3, 8, 2, 0);
    io_rdy = 0;
    access(4'h4, 0, 0, 1);
    chk("R6 ignored when off", last_len, 8);
    io_rdy = 1;

    // R6 waiting enabled: card holds ready low
    config_t(2, 3, 8, 2, 1);
    bus_din = 16'h5A5A;
    io_rdy = 0;
    start(4'h0, 0, 0, 1);
    repeat (10) @(posedge clk);
    #1 io_rdy = 1;
    wait_quiet();
    chk("R6 stretched", (last_len > 8) ? 1 : 0, 1);
    chk("R7 read after wait", rsp_rdata, 16'h5A5A);

    // R9 R10 request held during a read and its float interval
    config_t(2, 3, 8, 2, 0);
    d0 = n_done;
    start(4'h5, 0, 0, 0);
    start(4'h6, 0, 0, 0);
    wait_quiet();
    chk("R10 both served", n_done - d0, 2);
    chk("R9 gap after read", last_gap, 3);

    // R9 write followed by held write
    d0 = n_done;
    start(4'h1, 16'h0102, 1, 1);
    start(4'h2, 16'h0304, 1, 1);
    wait_quiet();
    chk("R10 writes served", n_done - d0, 2);
    chk("R9 gap after write", last_gap, 1);

    // R10 third start while slot full is dropped
    d0 = n_done;
    start(4'h1, 0, 0, 0);
    start(4'h2, 0, 0, 0);
    start(4'h3, 0, 0, 0);
    wait_quiet();
    chk("R10 extra dropped", n_done - d0, 2);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule